// File: doc/BRIEF.md
# Affine Vector Lane Expander

The block turns a compact description of an affine vector into the full vector of lane words. The compact form is a 32-bit base and a 3-bit stride code. Each lane i receives base + i × stride, and the stride is restricted to zero or a power of two. A load path that keeps vectors in this compact form places the unit between the compact store and the register write-back.

No multiplier is used. Each lane shifts its own constant lane index left by the amount the code selects, then adds the broadcast base in a 32-bit adder. A per-lane request mask forces the unrequested lanes to zero. The result is captured in an output register together with a valid flag, so the unit adds exactly one cycle to the load. The output register keeps its contents in cycles with no request.

Top module: `affine_lane_expander`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted request, valid_o is 0 and every bit of vec_o is 0.
- R2: For an accepted request, lane i of vec_o (bits 32*i+31 down to 32*i) equals base_i + i × stride, where i runs from 0 to 31.
- R3: Stride code 0 means stride zero: every requested lane equals base_i.
- R4: Stride code c from 1 to 7 means stride 2^(c-1), so the strides run from 1 up to 64.
- R5: Lane sums wrap modulo 2^32.
- R6: When mask_i bit i is 0, lane i of vec_o is 0 for that request. Mask bit i controls lane i only.
- R7: valid_o is high in the cycle after valid_i is high and low in the cycle after valid_i is low. vec_o shows the result of a request in that same following cycle.
- R8: In a cycle where valid_i is low, vec_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| base_i | input | 32 | Broadcast base word |
| code_i | input | 3 | Stride code: 0 is stride zero, c > 0 is stride 2^(c-1) |
| mask_i | input | 32 | Per-lane request mask, bit i for lane i |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| vec_o | output | 1024 | Expanded vector, lane i in bits 32*i+31:32*i |

## Verification
Every stride code is driven against several bases, and each one shows a distinct lane-to-lane difference. A wrong shift amount or an off-by-one in the code mapping therefore stands out at once. Bases near 2^32 with the largest stride separate a correct wrapping adder from a truncated or saturating one.

Full, empty, alternating and single-bit masks show that each mask bit gates only its own lane. Back-to-back requests with idle gaps between them expose any extra pipeline stage or any output change during an idle cycle.

// File: rtl/ale_pkg.sv
package ale_pkg;
  parameter int LANES  = 32;
  parameter int WORD_W = 32;
  parameter int CODE_W = 3;

  localparam int LANE_ID_W = $clog2(LANES);
  localparam int VEC_W     = LANES * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/ale_lane_shift.sv
module ale_lane_shift
  import ale_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  code_t code_i,
  output word_t ofs_o
);
  localparam logic [LANE_ID_W-1:0] LaneId = LANE_ID_W'(LANE_IDX);

  // code 0 is the reserved zero-stride value
  always_comb begin
    ofs_o = '0;
    if (code_i != '0) ofs_o = WORD_W'(LaneId) << (code_i - CODE_W'(1));
  end
endmodule

// File: rtl/ale_lane_add.sv
module ale_lane_add
  import ale_pkg::*;
(
  input  word_t base_i,
  input  word_t ofs_i,
  input  logic  en_i,
  output word_t sum_o
);
  always_comb sum_o = en_i ? (base_i + ofs_i) : '0;
endmodule

// File: rtl/affine_lane_expander.sv
module affine_lane_expander
  import ale_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LANES-1:0]  mask_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  word_t lane_d [LANES];
  word_t lane_q [LANES];
  logic  valid_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    word_t ofs;

    ale_lane_shift #(.LANE_IDX(i)) u_shift (
      .code_i (code_i),
      .ofs_o  (ofs)
    );

    ale_lane_add u_add (
      .base_i (base_i),
      .ofs_i  (ofs),
      .en_i   (mask_i[i]),
      .sum_o  (lane_d[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q[i] <= '0;
      else if (valid_i) lane_q[i] <= lane_d[i];
    end

    assign vec_o[i*WORD_W +: WORD_W] = lane_q[i];

    // R6: unrequested lane is zero next cycle
    p_masked_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !mask_i[i]) |=> (vec_o[i*WORD_W +: WORD_W] == '0));

    // R3: zero stride gives the base on every requested lane
    p_uniform_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mask_i[i] && code_i == '0) |=>
        (vec_o[i*WORD_W +: WORD_W] == $past(base_i)));

    if (i > 0) begin : g_step
      // R4: neighbouring requested lanes differ by the coded stride
      p_stride_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i[i] && mask_i[i-1] && code_i != '0) |=>
          (vec_o[i*WORD_W +: WORD_W] - vec_o[(i-1)*WORD_W +: WORD_W]
            == (WORD_W'(1) << ($past(code_i) - CODE_W'(1)))));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  assign valid_o = valid_q;

  // R2: lane 0 carries the base
  p_lane0_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i[0]) |=> (vec_o[WORD_W-1:0] == $past(base_i)));

  // R7: one cycle of latency on the valid flag
  p_valid_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R8: idle cycles leave the output untouched
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(vec_o));
endmodule

// File: tb/affine_lane_expander_tb.sv
`timescale 1ns/1ps
module affine_lane_expander_tb;
  localparam int N  = 32;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  base_i = '0;
  logic [2:0]    code_i = '0;
  logic [N-1:0]  mask_i = '0;
  logic          valid_o;
  logic [N*W-1:0] vec_o;

  logic [N*W-1:0] exp_vec = '0;
  logic           exp_valid = 1'b0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  affine_lane_expander u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_i),
    .base_i  (base_i),
    .code_i  (code_i),
    .mask_i  (mask_i),
    .valid_o (valid_o),
    .vec_o   (vec_o)
  );

  function automatic logic [N*W-1:0] model(logic [W-1:0] b, int c, logic [N-1:0] m);
    logic [N*W-1:0] v;
    longint stride;
    v = '0;
    stride = (c == 0) ? 0 : (longint'(1) << (c - 1));
    for (int i = 0; i < N; i++) begin
      longint s;
      s = (longint'(b) + longint'(i) * stride) % (longint'(1) << 32);
      if (m[i]) v[i*W +: W] = s[31:0];
    end
    return v;
  endfunction

  task automatic check(string tag);
    checks++;
    if (vec_o !== exp_vec) begin
      fails++;
      for (int i = 0; i < N; i++)
        if (vec_o[i*W +: W] !== exp_vec[i*W +: W]) begin
          $display("FAIL %s lane %0d: got %h expected %h", tag, i,
                   vec_o[i*W +: W], exp_vec[i*W +: W]);
          break;
        end
    end
    checks++;
    if (valid_o !== exp_valid) begin
      fails++;
      $display("FAIL %s valid_o: got %b expected %b", tag, valid_o, exp_valid);
    end
  endtask

  task automatic cycle(bit v, logic [W-1:0] b, int c, logic [N-1:0] m, string tag);
    @(negedge clk);
    valid_i = v; base_i = b; code_i = 3'(c); mask_i = m;
    @(posedge clk);
    if (v) exp_vec = model(b, c, m);
    exp_valid = v;
    #1 check(tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a request presented while reset is held
    valid_i = 1'b1; base_i = 32'h1234_5678; mask_i = '1;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after release");

    // R4 and R2: every stride code, full mask
    for (int c = 1; c < 8; c++) cycle(1'b1, 32'h0000_1000 + 32'(c), c, '1, "R4");
    // R3: zero stride
    cycle(1'b1, 32'hDEAD_BEEF, 0, '1, "R3");
    cycle(1'b1, 32'h0, 0, '1, "R3 zero base");
    // R2: mixed bases
    cycle(1'b1, 32'h8000_0000, 3, '1, "R2");
    cycle(1'b1, 32'h0000_0040, 7, '1, "R2");
    // R5: wrap
    cycle(1'b1, 32'hFFFF_FFF0, 7, '1, "R5");
    cycle(1'b1, 32'hFFFF_FFFF, 1, '1, "R5");
    // R6: masks
    cycle(1'b1, 32'h0000_0100, 2, 32'h5555_5555, "R6 alternate");
    cycle(1'b1, 32'h0000_0100, 2, 32'hAAAA_AAAA, "R6 alternate");
    cycle(1'b1, 32'hCAFE_0000, 5, 32'h0000_0000, "R6 empty");
    cycle(1'b1, 32'hCAFE_0000, 5, 32'h8000_0000, "R6 top lane");
    cycle(1'b1, 32'hCAFE_0000, 5, 32'h0000_FFFF, "R6 low half");
    // R8 and R7: idle cycles hold output, valid drops
    cycle(1'b1, 32'h7777_0000, 4, '1, "R7");
    cycle(1'b0, 32'h1111_1111, 6, 32'h0F0F_0F0F, "R8 hold");
    cycle(1'b0, 32'h2222_2222, 0, '0, "R8 hold");
    cycle(1'b1, 32'h0000_0005, 6, 32'hFFFF_0000, "R7 resume");
    // back-to-back sweep
    for (int k = 0; k < 40; k++)
      cycle(k % 5 != 4, 32'h9E37_79B9 * 32'(k + 1), k % 8,
            32'hFFFF_FFFF >> (k % 32), "R2 sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule